// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a binary up/down counter, four bits wide by default, that advances on rising edges of one count line and retreats on rising edges of another. A count edge on either line is honoured only while the opposite line rests high. A master clear and an active-low parallel load act on the count at the next system clock, with no count edge needed. The clear wins over the load, and the load wins over counting.

Both count lines are treated as asynchronous. Each passes through a two-flop synchronizer on the system clock, and a rising edge is found by comparing the synchronized sample with the one before it. The active-low carry output falls while the count sits at its top value and the up line is in its low phase. The active-low borrow output falls while the count sits at zero and the down line is in its low phase. Wiring carry and borrow straight into the up and down lines of a further stage builds wider counters. Each stage then steps when the stage below it wraps.

Top module: `updown_dual_counter`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low, the count goes to 0 and `carry_n` and `borrow_n` go high.
- R2: A high `clear` forces the count to 0 at the next system clock edge, whatever `load_n`, `jam` and the count lines do.
- R3: With `clear` low and `load_n` low, the count takes the value of `jam` at the next system clock edge, and count edges are ignored. Bit i of `jam` goes to bit i of `count`.
- R4: A rising edge on `up_clk` while `dn_clk` is high adds one to the count, and 15 wraps to 0. The new count shows at the third system clock edge after the input changes.
- R5: A rising edge on `dn_clk` while `up_clk` is high subtracts one from the count, and 0 wraps to 15.
- R6: A rising edge on one count line while the other line is low leaves the count unchanged.
- R7: Rising edges on both count lines sampled in the same system clock cycle leave the count unchanged.
- R8: `carry_n` is low exactly when the count is 15 and the synchronized `up_clk` level is low, and is high otherwise.
- R9: `borrow_n` is low exactly when the count is 0 and the synchronized `dn_clk` level is low, and is high otherwise.
- R10: Two stages, with the lower stage's `carry_n` and `borrow_n` driving the upper stage's `up_clk` and `dn_clk`, count as one 8-bit counter, wrapping in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Master clear, active high |
| load_n | input | 1 | Parallel load enable, active low |
| jam | input | WIDTH | Parallel load value |
| up_clk | input | 1 | Count-up line, asynchronous |
| dn_clk | input | 1 | Count-down line, asynchronous |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry, top count during the up line's low phase |
| borrow_n | output | 1 | Active-low borrow, zero count during the down line's low phase |

## Verification
The hardest cases to reach are the ones where both count lines move at once. A simultaneous rise must land in the same synchronized cycle, and a rise on one line must arrive while the other line is held low. From idle with both lines high, the stimulus lowers both lines on one edge and raises them on one edge, so both rises reach the edge detectors together. For the gating case, it lowers the blocking line first, then pulses the other line, and reads the count before releasing anything. The chained pair is driven through random runs of pulses, with loads to 15 and 0 mixed in, so the carry and borrow hand-offs across the nibble boundary happen many times.

// File: rtl/udc_pkg.sv
// Shared definitions for the dual-clock up/down counter.
// Assumes: nothing beyond IEEE 1800-2017.
package udc_pkg;

    // Action applied to the count register in one system clock cycle.
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4
    } udc_op_e;

    // Number of count lines per counter (up and down).
    localparam int unsigned UDC_LINES = 2;

endpackage

// File: rtl/udc_edge_sync.sv
// Two-flop synchronizer with rising-edge detection for one count line.
// Assumes: async_in may change at any time relative to clk; the line rests
// at IDLE, so every stage resets to IDLE and no edge is seen at reset exit.
module udc_edge_sync #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);

    logic meta_q;
    logic stable_q;
    logic prev_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= IDLE;
            stable_q <= IDLE;
            prev_q   <= IDLE;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
            prev_q   <= stable_q;
        end
    end

    // Synchronized level and single-cycle rising-edge strobe.
    always_comb begin
        level = stable_q;
        rise  = stable_q & ~prev_q;
    end

endmodule

// File: rtl/udc_count_core.sv
// Count register with clear, parallel load and gated up/down stepping.
// Assumes: clear, load_n and jam are synchronous to clk; the rise strobes
// and levels come from the synchronizers, so they line up in time.
// Priority: clear, then load, then counting. Simultaneous valid steps cancel.
module udc_count_core
    import udc_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load_n,
    input  logic [WIDTH-1:0] jam,
    input  logic             up_rise,
    input  logic             dn_rise,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    udc_op_e          op;
    logic             up_ok;
    logic             dn_ok;
    logic [WIDTH-1:0] count_q;

    // Qualify each step by the level of the opposite line, then pick the action.
    always_comb begin
        up_ok = up_rise & dn_lvl;
        dn_ok = dn_rise & up_lvl;
        if (clear)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (up_ok && !dn_ok)
            op = OP_INC;
        else if (dn_ok && !up_ok)
            op = OP_DEC;
        else
            op = OP_HOLD;
    end

    // Apply the selected action; arithmetic wraps modulo 2**WIDTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: count_q <= '0;
                OP_LOAD:  count_q <= jam;
                OP_INC:   count_q <= count_q + ONE;
                OP_DEC:   count_q <= count_q - ONE;
                default:  count_q <= count_q;
            endcase
        end
    end

    assign count = count_q;

endmodule

// File: rtl/udc_term_decode.sv
// Decodes active-low carry and borrow from the registered count and the
// synchronized line levels.
// Assumes: count and levels are registered, so the outputs are glitch-free
// enough to drive the count lines of a following stage.
module udc_term_decode #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // Carry in the up line's low phase at top count; borrow mirrors it at zero.
    always_comb begin
        carry_n  = ~((count == TOP) & ~up_lvl);
        borrow_n = ~((count == '0)  & ~dn_lvl);
    end

endmodule

// File: rtl/updown_dual_counter.sv
// Top level: presettable up/down counter with separate count-up and
// count-down lines, active-low carry and borrow for chaining.
// Assumes: one system clock; count lines are asynchronous and slow compared
// with clk (each phase lasts at least three clk cycles).
module updown_dual_counter
    import udc_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load_n,
    input  logic [WIDTH-1:0] jam,
    input  logic             up_clk,
    input  logic             dn_clk,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam int unsigned UP_IDX = 0;
    localparam int unsigned DN_IDX = 1;

    logic [UDC_LINES-1:0] line_in;
    logic [UDC_LINES-1:0] line_lvl;
    logic [UDC_LINES-1:0] line_rise;
    logic                 up_lvl;
    logic                 dn_lvl;
    logic                 up_rise;
    logic                 dn_rise;

    // Gather the raw count lines into one vector.
    always_comb begin
        line_in[UP_IDX] = up_clk;
        line_in[DN_IDX] = dn_clk;
    end

    // One synchronizer and edge detector per count line.
    for (genvar g = 0; g < UDC_LINES; g++) begin : g_line
        udc_edge_sync #(.IDLE(1'b1)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (line_in[g]),
            .level    (line_lvl[g]),
            .rise     (line_rise[g])
        );
    end

    // Name the per-line results for the core and decoder.
    always_comb begin
        up_lvl  = line_lvl[UP_IDX];
        dn_lvl  = line_lvl[DN_IDX];
        up_rise = line_rise[UP_IDX];
        dn_rise = line_rise[DN_IDX];
    end

    udc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .load_n  (load_n),
        .jam     (jam),
        .up_rise (up_rise),
        .dn_rise (dn_rise),
        .up_lvl  (up_lvl),
        .dn_lvl  (dn_lvl),
        .count   (count)
    );

    udc_term_decode #(.WIDTH(WIDTH)) u_term (
        .count    (count),
        .up_lvl   (up_lvl),
        .dn_lvl   (dn_lvl),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

endmodule

// File: rtl/udc_checker.sv
// Property checker for updown_dual_counter, bound to every instance.
// Assumes: signals are sampled on the rising edge of clk.
module udc_checker #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             load_n,
    input logic [WIDTH-1:0] jam,
    input logic [WIDTH-1:0] count,
    input logic             carry_n,
    input logic             borrow_n,
    input logic             up_lvl,
    input logic             dn_lvl,
    input logic             up_rise,
    input logic             dn_rise
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    a_r3_load_jam: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load_n) |=> (count == $past(jam)));

    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && up_rise && dn_lvl && !dn_rise)
        |=> (count == WIDTH'($past(count) + 1'b1)));

    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && dn_rise && up_lvl && !up_rise)
        |=> (count == WIDTH'($past(count) - 1'b1)));

    a_r6_gated_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && up_rise && !dn_lvl) |=> $stable(count));

    a_r7_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && up_rise && dn_rise) |=> $stable(count));

    a_r8_carry_top: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count == TOP && !up_lvl));

    a_r9_borrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count == '0 && !dn_lvl));

endmodule

bind updown_dual_counter udc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .load_n   (load_n),
    .jam      (jam),
    .count    (count),
    .carry_n  (carry_n),
    .borrow_n (borrow_n),
    .up_lvl   (up_lvl),
    .dn_lvl   (dn_lvl),
    .up_rise  (up_rise),
    .dn_rise  (dn_rise)
);

// File: tb/updown_dual_counter_test.sv
module updown_dual_counter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] jam_lo = 4'd0;
    logic [3:0] jam_hi = 4'd0;
    logic       up_clk = 1'b1;
    logic       dn_clk = 1'b1;
    logic [3:0] cnt_lo, cnt_hi;
    logic       carry_lo, borrow_lo, carry_hi, borrow_hi;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model = 8'd0;

    always #10 clk = ~clk;

    updown_dual_counter #(.WIDTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .jam(jam_lo),
        .up_clk(up_clk), .dn_clk(dn_clk), .count(cnt_lo),
        .carry_n(carry_lo), .borrow_n(borrow_lo)
    );

    updown_dual_counter #(.WIDTH(4)) stage_hi (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .jam(jam_hi),
        .up_clk(carry_lo), .dn_clk(borrow_lo), .count(cnt_hi),
        .carry_n(carry_hi), .borrow_n(borrow_hi)
    );

    function automatic logic exp_carry(logic [3:0] c, logic up_level);
        return !((c == 4'hF) && !up_level);
    endfunction

    function automatic logic exp_borrow(logic [3:0] c, logic dn_level);
        return !((c == 4'h0) && !dn_level);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic chk_chain(input string req);
        chk(req, {cnt_hi, cnt_lo}, model);
    endtask

    // Up pulse on the lower stage; checks carry in the low phase (R8).
    task automatic pulse_up();
        up_clk = 1'b0;
        settle();
        chk("R8 carry low phase", carry_lo, exp_carry(model[3:0], 1'b0));
        up_clk = 1'b1;
        settle();
        model = model + 8'd1;
    endtask

    // Down pulse on the lower stage; checks borrow in the low phase (R9).
    task automatic pulse_dn();
        dn_clk = 1'b0;
        settle();
        chk("R9 borrow low phase", borrow_lo, exp_borrow(model[3:0], 1'b0));
        dn_clk = 1'b1;
        settle();
        model = model - 8'd1;
    endtask

    task automatic do_load(input logic [7:0] v);
        jam_hi = v[7:4];
        jam_lo = v[3:0];
        load_n = 1'b0;
        @(negedge clk);
        load_n = 1'b1;
        settle();
        model = v;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        summary();
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h0d15_c0de);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 count", cnt_lo, 0);
        chk("R1 carry", carry_lo, 1);
        chk("R1 borrow", borrow_lo, 1);
        rst_n = 1'b1;
        settle();
        chk("R1 after release", {cnt_hi, cnt_lo}, 0);

        // R3: load latency and value
        jam_lo = 4'd9; jam_hi = 4'd2; load_n = 1'b0;
        @(negedge clk);
        chk("R3 load one edge", cnt_lo, 9);
        jam_lo = 4'd4;
        @(negedge clk);
        chk("R3 load follows jam", cnt_lo, 4);
        load_n = 1'b1;
        settle();
        model = 8'h24;

        // R3: load overrides an up edge
        up_clk = 1'b0; settle();
        jam_lo = 4'd7; load_n = 1'b0; up_clk = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 load beats count", cnt_lo, 7);
        load_n = 1'b1; settle();
        model = 8'h27;

        // R2: clear overrides load
        clear = 1'b1; load_n = 1'b0;
        @(negedge clk);
        chk("R2 clear beats load", {cnt_hi, cnt_lo}, 0);
        clear = 1'b0; load_n = 1'b1;
        settle();
        model = 8'h00;

        // R4: latency of an up step
        do_load(8'h05);
        up_clk = 1'b0; settle();
        up_clk = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R4 not yet stepped", cnt_lo, 5);
        @(negedge clk);
        chk("R4 stepped third edge", cnt_lo, 6);
        settle();
        model = 8'h06;

        // R4 / R5: wrap in the lower stage and chain (R10)
        do_load(8'h0F);
        pulse_up();
        chk_chain("R4 R10 wrap up carries");
        chk("R4 low wraps to 0", cnt_lo, 0);
        pulse_dn();
        chk_chain("R5 R10 wrap down borrows");
        chk("R5 low wraps to 15", cnt_lo, 15);
        do_load(8'hFF);
        pulse_up();
        chk_chain("R10 full wrap up");
        pulse_dn();
        chk_chain("R10 full wrap down");

        // R6: up edge while down line low is ignored
        do_load(8'h35);
        dn_clk = 1'b0; settle();
        up_clk = 1'b0; settle();
        up_clk = 1'b1; settle();
        chk("R6 gated up ignored", cnt_lo, 5);
        // down edge while up line low is ignored
        up_clk = 1'b0; settle();
        dn_clk = 1'b1; settle();
        chk("R6 gated down ignored", cnt_lo, 5);
        chk("R8 carry high off top", carry_lo, 1);
        up_clk = 1'b1; settle();
        model = 8'h36;
        chk_chain("R4 release steps up");

        // R7: simultaneous rises cancel
        up_clk = 1'b0; dn_clk = 1'b0; settle();
        up_clk = 1'b1; dn_clk = 1'b1; settle();
        chk_chain("R7 both rises hold");

        // R9: borrow idle high at zero with down line high
        do_load(8'h10);
        chk("R9 borrow high line high", borrow_lo, 1);
        chk("R8 carry idle high", carry_lo, 1);

        // Random mix against the 8-bit model
        for (int i = 0; i < 120; i++) begin
            int unsigned pick;
            pick = $urandom_range(0, 9);
            if (pick < 4) begin
                pulse_up();
            end else if (pick < 8) begin
                pulse_dn();
            end else if (pick == 8) begin
                case ($urandom_range(0, 2))
                    0: do_load({4'($urandom_range(0, 15)), 4'hF});
                    1: do_load({4'($urandom_range(0, 15)), 4'h0});
                    default: do_load(8'($urandom_range(0, 255)));
                endcase
            end else if (model[3:0] != 4'h0 && model[3:0] != 4'hF) begin
                up_clk = 1'b0; dn_clk = 1'b0; settle();
                up_clk = 1'b1; dn_clk = 1'b1; settle();
                chk_chain("R7 random both");
            end
            chk_chain("R10 random chain");
        end

        summary();
        $finish;
    end

endmodule